// File: doc/BRIEF.md
# Boot Shadow Memory Remap Controller

This block sits between a small microcontroller core and its on-chip code memories. It keeps a one-byte configuration register whose single writable bit, the shadow bit, chooses between two memory maps. After reset the part is in boot mode. A boot ROM answers instruction fetches in a low window and again in a high window. The code RAM sits in external-data space, where the boot firmware can load a program into it. Once loading is done, software sets the shadow bit. From the next clock edge the RAM answers instruction fetches from address zero, the boot ROM is visible only in its high window, and the RAM can no longer be written.

The other register fields are fixed by parameters and reset leaves them alone: a build flag (code RAM with boot ROM, or plain code ROM), a two-bit code-space size and a four-bit revision. In a ROM build the shadow bit still reads back, but it does not change the map. Decoding is purely combinational from the addresses and the current shadow bit. The block drives chip selects, offsets and read-data muxing for the memory arrays, which live outside it.

Top module: `boot_remap_ctrl`

## Requirements
- R1: `cfg_rdata` shows the build flag in bit 7 (1 = RAM build), the size code in bits 6:5, the revision in bits 4:1 and the shadow bit in bit 0. With the defaults (RAM build, size 2, revision 5) it reads CAh while the shadow bit is clear.
- R2: A write with `cfg_wdata[0]`=1 sets the shadow bit, and the new map applies from the clock edge that takes the write. A write with bit 0 clear leaves the shadow bit unchanged, and software has no way to clear it.
- R3: The shadow bit is cleared by the asynchronous power-up reset `rst_n` and by the synchronous function reset `func_rst`.
- R4: In boot mode, fetches from 0000h–17FFh and from 8000h–97FFh assert `boot_cs`, with `boot_addr` as the offset into the 6K ROM, and `fetch_data` returns `boot_q`.
- R5: In boot mode, a data access below the code-space size asserts `ram_cs` with `mem_addr` = `xd_addr`. `xd_rdata` returns `ram_q`, and `ram_we` follows `xd_wr`.
- R6: With the shadow bit set, fetches below the code-space size assert `ram_cs` and return `ram_q`. The boot ROM answers only in 8000h–97FFh, with offset = address − 8000h.
- R7: With the shadow bit set, `ram_we` is never asserted, and every data access returns FFh.
- R8: A fetch outside every window asserts no chip select and returns FFh. At most one code-side select is active at a time.
- R9: In a ROM build, fetches below the code-space size assert `crom_cs` and return `crom_q`. `boot_cs` is never asserted, the data side never reaches the RAM, and setting the shadow bit changes none of this.
- R10: The code-space size is 4K shifted left by the size code (00 = 4K, 01 = 8K, 10 = 16K, 11 = 32K). A fetch at exactly that size misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| func_rst | input | 1 | Synchronous function reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data (bit 0 used) |
| cfg_rdata | output | 8 | Register read value |
| fetch_en | input | 1 | Instruction fetch strobe |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| fetch_data | output | 8 | Fetched byte |
| xd_en | input | 1 | Data-space access strobe |
| xd_wr | input | 1 | Data-space write (1) or read (0) |
| xd_addr | input | ADDR_W | Data-space address |
| xd_rdata | output | 8 | Data-space read byte |
| boot_cs | output | 1 | Boot ROM select |
| boot_addr | output | BOOT_AW | Boot ROM offset |
| boot_q | input | 8 | Boot ROM read data |
| crom_cs | output | 1 | Code ROM select (ROM build) |
| crom_q | input | 8 | Code ROM read data |
| ram_cs | output | 1 | Code RAM select |
| ram_we | output | 1 | Code RAM write enable |
| mem_addr | output | MEM_AW | Code RAM / code ROM address |
| ram_q | input | 8 | Code RAM read data |

## Verification
The hardest case to reach is the switch itself. The map must stay in boot mode for the whole cycle in which the setting write is presented, and change only after that edge. The bench holds a fetch at 0000h across the write and samples the selects both before and after the edge. A second case is the behaviour of the sticky bit under resets. The bench sets the bit, tries to clear it by software, then applies each reset kind in turn. A second instance, configured as a ROM build, receives the same inputs, so its indifference to the shadow bit is observed under the same stimulus.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_BOOT = 2'd1,
      SRC_CROM = 2'd2,
      SRC_RAM  = 2'd3
   } code_src_e;

   localparam logic [7:0] FILL_BYTE = 8'hFF;

   // Code-space bytes for a two-bit size code: 4K doubling per step.
   function automatic int code_bytes(input int size_code);
      return 4096 << size_code;
   endfunction

endpackage

// File: rtl/remap_cfg_reg.sv
module remap_cfg_reg #(
   parameter bit         BUILD_RAM = 1'b1,
   parameter int         SIZE_CODE = 2,
   parameter logic [3:0] REVISION  = 4'h5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       func_rst,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       shadow
);

   logic shadow_q;
   logic unused_wdata;

   assign unused_wdata = ^wr_data[7:1];

   // Sticky bit: software may only set it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= 1'b0;
      end else if (func_rst) begin
         shadow_q <= 1'b0;
      end else if (wr_en && wr_data[0]) begin
         shadow_q <= 1'b1;
      end
   end

   assign shadow  = shadow_q;
   assign rd_data = {BUILD_RAM, 2'(SIZE_CODE), REVISION, shadow_q};

   assert_shadow_sticky_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_q && !func_rst) |=> shadow_q);

   assert_shadow_set_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0] && !func_rst) |=> shadow_q);

   assert_func_clear_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      func_rst |=> !shadow_q);

endmodule

// File: rtl/remap_code_dec.sv
module remap_code_dec
   import boot_remap_pkg::*;
#(
   parameter int                BUILD_RAM  = 1,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] BOOT_BASE  = 16'h8000,
   parameter int                BOOT_BYTES = 6144,
   parameter int                BOOT_AW    = 13,
   parameter int                CODE_BYTES = 16384
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               shadow,
   output code_src_e          src,
   output logic [BOOT_AW-1:0] boot_off
);

   localparam logic [ADDR_W:0] CODE_LIM = (ADDR_W+1)'(CODE_BYTES);
   localparam logic [ADDR_W:0] BOOT_LIM = (ADDR_W+1)'(BOOT_BYTES);
   localparam logic [ADDR_W:0] HI_LO    = {1'b0, BOOT_BASE};
   localparam logic [ADDR_W:0] HI_END   = HI_LO + BOOT_LIM;

   logic [ADDR_W:0] a_ext;
   logic            in_code;

   assign a_ext   = {1'b0, addr};
   assign in_code = a_ext < CODE_LIM;

   if (BUILD_RAM != 0) begin : g_ram_build
      logic in_low_boot;
      logic in_high_boot;

      assign in_low_boot  = a_ext < BOOT_LIM;
      assign in_high_boot = (a_ext >= HI_LO) && (a_ext < HI_END);

      always_comb begin
         if (in_high_boot) begin
            src = SRC_BOOT;
         end else if (!shadow && in_low_boot) begin
            src = SRC_BOOT;
         end else if (shadow && in_code) begin
            src = SRC_RAM;
         end else begin
            src = SRC_NONE;
         end
      end

      assign boot_off = in_high_boot ? BOOT_AW'(addr - BOOT_BASE) : BOOT_AW'(addr);
   end else begin : g_rom_build
      logic unused_shadow;

      assign unused_shadow = shadow;
      assign src           = in_code ? SRC_CROM : SRC_NONE;
      assign boot_off      = '0;
   end

endmodule

// File: rtl/remap_data_dec.sv
module remap_data_dec #(
   parameter int BUILD_RAM = 1,
   parameter int ADDR_W    = 16,
   parameter int RAM_BYTES = 16384
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              shadow,
   output logic              hit
);

   localparam logic [ADDR_W:0] RAM_LIM = (ADDR_W+1)'(RAM_BYTES);

   if (BUILD_RAM != 0) begin : g_ram_build
      // The data window exists only while the RAM is not yet code.
      assign hit = !shadow && ({1'b0, addr} < RAM_LIM);
   end else begin : g_rom_build
      logic unused_in;

      assign unused_in = shadow ^ (^addr);
      assign hit       = 1'b0;
   end

endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
   import boot_remap_pkg::*;
#(
   parameter bit                BUILD_RAM  = 1'b1,
   parameter int                SIZE_CODE  = 2,
   parameter logic [3:0]        REVISION   = 4'h5,
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] BOOT_BASE  = 16'h8000,
   parameter int                BOOT_BYTES = 6144,
   parameter int                BOOT_AW    = $clog2(BOOT_BYTES),
   parameter int                MEM_AW     = 12 + SIZE_CODE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               func_rst,
   input  logic               cfg_wr,
   input  logic [7:0]         cfg_wdata,
   output logic [7:0]         cfg_rdata,
   input  logic               fetch_en,
   input  logic [ADDR_W-1:0]  fetch_addr,
   output logic [7:0]         fetch_data,
   input  logic               xd_en,
   input  logic               xd_wr,
   input  logic [ADDR_W-1:0]  xd_addr,
   output logic [7:0]         xd_rdata,
   output logic               boot_cs,
   output logic [BOOT_AW-1:0] boot_addr,
   input  logic [7:0]         boot_q,
   output logic               crom_cs,
   input  logic [7:0]         crom_q,
   output logic               ram_cs,
   output logic               ram_we,
   output logic [MEM_AW-1:0]  mem_addr,
   input  logic [7:0]         ram_q
);

   localparam int CODE_BYTES = code_bytes(SIZE_CODE);

   // Elaboration-time parameter checks
   if (SIZE_CODE < 0 || SIZE_CODE > 3) begin : g_bad_size
      $error("SIZE_CODE must be 0..3");
   end
   if (BOOT_AW != $clog2(BOOT_BYTES)) begin : g_bad_boot_aw
      $error("BOOT_AW must equal clog2(BOOT_BYTES)");
   end
   if (MEM_AW != 12 + SIZE_CODE) begin : g_bad_mem_aw
      $error("MEM_AW must equal 12 + SIZE_CODE");
   end
   if (int'(BOOT_BASE) + BOOT_BYTES > (1 << ADDR_W)) begin : g_bad_base
      $error("boot window exceeds address space");
   end
   if (CODE_BYTES > (1 << ADDR_W)) begin : g_bad_code
      $error("code space exceeds address space");
   end

   logic      shadow_bit;
   logic      shadow_eff;
   logic      data_hit;
   code_src_e fsrc;

   remap_cfg_reg #(
      .BUILD_RAM (BUILD_RAM),
      .SIZE_CODE (SIZE_CODE),
      .REVISION  (REVISION)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .func_rst (func_rst),
      .wr_en    (cfg_wr),
      .wr_data  (cfg_wdata),
      .rd_data  (cfg_rdata),
      .shadow   (shadow_bit)
   );

   // A ROM build ignores the shadow bit for decoding.
   assign shadow_eff = BUILD_RAM && shadow_bit;

   remap_code_dec #(
      .BUILD_RAM  (int'(BUILD_RAM)),
      .ADDR_W     (ADDR_W),
      .BOOT_BASE  (BOOT_BASE),
      .BOOT_BYTES (BOOT_BYTES),
      .BOOT_AW    (BOOT_AW),
      .CODE_BYTES (CODE_BYTES)
   ) u_code (
      .addr     (fetch_addr),
      .shadow   (shadow_eff),
      .src      (fsrc),
      .boot_off (boot_addr)
   );

   remap_data_dec #(
      .BUILD_RAM (int'(BUILD_RAM)),
      .ADDR_W    (ADDR_W),
      .RAM_BYTES (CODE_BYTES)
   ) u_data (
      .addr   (xd_addr),
      .shadow (shadow_eff),
      .hit    (data_hit)
   );

   assign boot_cs = fetch_en && (fsrc == SRC_BOOT);
   assign crom_cs = fetch_en && (fsrc == SRC_CROM);

   // The RAM has one port: the data side owns it in boot mode,
   // the fetch side after the remap.
   always_comb begin
      if (shadow_eff || !BUILD_RAM) begin
         ram_cs   = fetch_en && (fsrc == SRC_RAM);
         mem_addr = MEM_AW'(fetch_addr);
      end else begin
         ram_cs   = xd_en && data_hit;
         mem_addr = MEM_AW'(xd_addr);
      end
   end

   assign ram_we = xd_en && xd_wr && data_hit;

   always_comb begin
      unique case (fsrc)
         SRC_BOOT: fetch_data = boot_q;
         SRC_CROM: fetch_data = crom_q;
         SRC_RAM:  fetch_data = ram_q;
         default:  fetch_data = FILL_BYTE;
      endcase
   end

   assign xd_rdata = data_hit ? ram_q : FILL_BYTE;

   assert_no_write_shadow_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[0] && BUILD_RAM |-> !ram_we);

   assert_one_code_sel_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({boot_cs, crom_cs, ram_cs && shadow_eff}));

   assert_low_boot_gone_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_eff && fetch_en && (fetch_addr < BOOT_BASE)) |-> !boot_cs);

   assert_data_blank_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[0] && BUILD_RAM) |-> (xd_rdata == FILL_BYTE));

   if (!BUILD_RAM) begin : g_rom_checks
      assert_no_boot_rom_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         !boot_cs && !ram_cs);
   end

endmodule

// File: tb/boot_remap_ctrl_tb.sv
`timescale 1ns/1ps
module boot_remap_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        func_rst = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic        fetch_en = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic        xd_en = 1'b0;
   logic        xd_wr = 1'b0;
   logic [15:0] xd_addr = '0;
   logic [7:0]  boot_q = 8'hB0;
   logic [7:0]  crom_q = 8'hC0;
   logic [7:0]  ram_q = 8'hA0;

   logic [7:0]  cfg_rdata, fetch_data, xd_rdata;
   logic        boot_cs, crom_cs, ram_cs, ram_we;
   logic [12:0] boot_addr;
   logic [13:0] mem_addr;

   logic [7:0]  r_cfg_rdata, r_fetch_data, r_xd_rdata;
   logic        r_boot_cs, r_crom_cs, r_ram_cs, r_ram_we;
   logic [12:0] r_boot_addr;
   logic [12:0] r_mem_addr;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   boot_remap_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .func_rst(func_rst),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
      .xd_en(xd_en), .xd_wr(xd_wr), .xd_addr(xd_addr), .xd_rdata(xd_rdata),
      .boot_cs(boot_cs), .boot_addr(boot_addr), .boot_q(boot_q),
      .crom_cs(crom_cs), .crom_q(crom_q),
      .ram_cs(ram_cs), .ram_we(ram_we), .mem_addr(mem_addr), .ram_q(ram_q)
   );

   boot_remap_ctrl #(.BUILD_RAM(1'b0), .SIZE_CODE(1)) u_rom (
      .clk(clk), .rst_n(rst_n), .func_rst(func_rst),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(r_cfg_rdata),
      .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_data(r_fetch_data),
      .xd_en(xd_en), .xd_wr(xd_wr), .xd_addr(xd_addr), .xd_rdata(r_xd_rdata),
      .boot_cs(r_boot_cs), .boot_addr(r_boot_addr), .boot_q(boot_q),
      .crom_cs(r_crom_cs), .crom_q(crom_q),
      .ram_cs(r_ram_cs), .ram_we(r_ram_we), .mem_addr(r_mem_addr), .ram_q(ram_q)
   );

   typedef struct packed {
      logic        sh;
      logic [15:0] fa;
      logic [15:0] xa;
      logic        xw;
      logic        e_boot;
      logic        e_ram;
      logic        e_we;
      logic [7:0]  e_fd;
      logic [7:0]  e_xd;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 8'hB0, 8'hA0}, // R4 R5
      '{1'b0, 16'h8000, 16'h3FFF, 1'b0, 1'b1, 1'b1, 1'b0, 8'hB0, 8'hA0}, // R4 R5
      '{1'b0, 16'h97FF, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0, 8'hB0, 8'hFF}, // R4 R10
      '{1'b0, 16'h9800, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hA0}, // R8
      '{1'b0, 16'h1800, 16'h0100, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hA0}, // R8
      '{1'b0, 16'h17FF, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'hB0, 8'hA0}, // R4
      '{1'b1, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA0, 8'hFF}, // R6 R7
      '{1'b1, 16'h3FFF, 16'h2000, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA0, 8'hFF}, // R6 R7
      '{1'b1, 16'h4000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF}, // R10
      '{1'b1, 16'h8000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'hB0, 8'hFF}, // R6
      '{1'b1, 16'h97FF, 16'h3FFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'hB0, 8'hFF}, // R6
      '{1'b1, 16'h9800, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF}  // R8
   };

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic set_shadow(input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic drive(input logic [15:0] fa, input logic [15:0] xa, input logic xw);
      @(negedge clk);
      fetch_addr = fa;
      xd_addr = xa;
      xd_wr = xw;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      bit sh_on;
      sh_on = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fetch_en = 1'b1;
      xd_en = 1'b1;
      #1;
      // R1 R3: layout after power-up reset
      chk("R1", "cfg_rdata ram build", 16'(cfg_rdata), 16'hCA);
      chk("R1", "cfg_rdata rom build", 16'(r_cfg_rdata), 16'h2A);

      // R2: writing zero does not set the bit
      set_shadow(8'hFE);
      #1;
      chk("R2", "zero write keeps clear", 16'(cfg_rdata), 16'hCA);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].sh && !sh_on) begin
            set_shadow(8'h01);
            sh_on = 1'b1;
         end
         drive(VECS[i].fa, VECS[i].xa, VECS[i].xw);
         chk(VECS[i].sh ? "R6" : "R4", "boot_cs", 16'(boot_cs), 16'(VECS[i].e_boot));
         chk(VECS[i].sh ? "R6" : "R5", "ram_cs", 16'(ram_cs), 16'(VECS[i].e_ram));
         chk(VECS[i].sh ? "R7" : "R5", "ram_we", 16'(ram_we), 16'(VECS[i].e_we));
         chk("R8", "fetch_data", 16'(fetch_data), 16'(VECS[i].e_fd));
         chk(VECS[i].sh ? "R7" : "R5", "xd_rdata", 16'(xd_rdata), 16'(VECS[i].e_xd));
      end

      // R2: software cannot clear
      set_shadow(8'h00);
      #1;
      chk("R2", "clear attempt ignored", 16'(cfg_rdata), 16'hCB);
      // R6: offsets after remap
      drive(16'h8123, 16'h0000, 1'b0);
      chk("R6", "boot offset high", 16'(boot_addr), 16'h0123);
      drive(16'h1234, 16'h0000, 1'b0);
      chk("R6", "ram fetch addr", 16'(mem_addr), 16'h1234);
      // R9: ROM build with shadow set still plain
      drive(16'h0000, 16'h0000, 1'b1);
      chk("R9", "rom shadow readback", 16'(r_cfg_rdata), 16'h2B);
      chk("R9", "rom crom_cs", 16'(r_crom_cs), 16'h1);
      chk("R9", "rom fetch_data", 16'(r_fetch_data), 16'hC0);
      chk("R9", "rom ram_cs", 16'(r_ram_cs), 16'h0);
      chk("R9", "rom ram_we", 16'(r_ram_we), 16'h0);
      chk("R9", "rom xd_rdata", 16'(r_xd_rdata), 16'hFF);

      // R3: function reset
      @(negedge clk);
      func_rst = 1'b1;
      @(negedge clk);
      func_rst = 1'b0;
      #1;
      chk("R3", "func reset clears", 16'(cfg_rdata), 16'hCA);
      drive(16'h0000, 16'h2ABC, 1'b0);
      chk("R3", "boot map back", 16'(boot_cs), 16'h1);
      chk("R5", "data mem_addr", 16'(mem_addr), 16'h2ABC);
      drive(16'h0ABC, 16'h0000, 1'b0);
      chk("R4", "boot offset low", 16'(boot_addr), 16'h0ABC);

      // R2: takes effect only after the edge
      @(negedge clk);
      fetch_addr = 16'h0000;
      cfg_wr = 1'b1;
      cfg_wdata = 8'h01;
      #1;
      chk("R2", "boot before edge", 16'(boot_cs), 16'h1);
      chk("R2", "ram idle before edge", 16'(fetch_data), 16'hB0);
      @(negedge clk);
      cfg_wr = 1'b0;
      cfg_wdata = '0;
      #1;
      chk("R2", "boot after edge", 16'(boot_cs), 16'h0);
      chk("R2", "ram after edge", 16'(ram_cs), 16'h1);

      // R3: power-up reset
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R3", "por clears", 16'(cfg_rdata), 16'hCA);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 R10: ROM build, 8K code space
      drive(16'h8000, 16'h0000, 1'b0);
      chk("R9", "rom no boot_cs", 16'(r_boot_cs), 16'h0);
      chk("R9", "rom 8000 blank", 16'(r_fetch_data), 16'hFF);
      drive(16'h1FFF, 16'h0000, 1'b0);
      chk("R10", "rom last byte", 16'(r_crom_cs), 16'h1);
      drive(16'h2000, 16'h0000, 1'b0);
      chk("R10", "rom size edge", 16'(r_crom_cs), 16'h0);
      chk("R8", "rom miss data", 16'(r_fetch_data), 16'hFF);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule